// File: doc/BRIEF.md
# Two-Dimensional Word Copy Address Generator

This block is the transfer engine that works through one already-fetched copy descriptor. It takes a control word, a source and a destination base address, a length word and a stride word, all presented together with a one-cycle start strobe. From these it issues a series of 32-bit word reads and writes, each held until the memory side raises its ready input. The copy is either a single linear run, or a rectangle of rows. In the rectangle case, signed row-to-row strides are applied to both pointers between rows.

Per descriptor, the source or destination pointer can step by one word per beat or stay fixed. The read side can be suppressed, in which case zero is written. The write side can also be suppressed, so that reads are issued and their data is discarded. A live remaining-length value follows the transfer beat by beat, so a status register elsewhere can show progress. A one-cycle completion pulse marks the end of the descriptor.

Top module: `dma2d_agen`

## Requirements
- R1: After synchronous reset, busy, rd_req, wr_req and done are 0 and remain_len is 0.
- R2: With control bit 1 clear (linear), the whole length word is the byte count of a single row and no stride is applied. A row of N bytes takes ceil(N/4) word beats, and the last beat leaves 0 bytes.
- R3: With control bit 1 set (2D), the row count is length bits [29:16], the bytes per row are length bits [15:0], and bits [31:30] are ignored. After every row except the last, the signed stride in stride bits [15:0] is added to the source pointer and the signed stride in bits [31:16] is added to the destination pointer.
- R4: Control bit 8 makes the source pointer step by 4 after each beat. Control bit 4 does the same for the destination pointer. When its bit is clear, a pointer stays put within a row.
- R5: With control bit 11 set, no read is requested and every word written is 0.
- R6: With control bit 7 set, no write is requested, and reads are still issued at the addresses R3/R4 give.
- R7: rd_req and wr_req are never high together. A raised request keeps its address (and write data) until the matching ready is seen. A beat reads first, then writes the read word.
- R8: At start, remain_len loads the decoded length: in linear mode the whole length word; in 2D mode rows in [29:16], bytes per row in [15:0], zeros above. One cycle after each beat completes, remain_len shows the bytes left in the current row, and in 2D mode bits [29:16] show the rows left counting the current row.
- R9: done is high for exactly one cycle, in the cycle after the final beat's last handshake. busy is low from that cycle on.
- R10: A descriptor with a byte count of 0, or a 2D descriptor with 0 rows, issues no request and raises done in the cycle after start.
- R11: start is ignored while busy is high; a running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe; the descriptor words are sampled with it |
| ctrl_word | input | 32 | Mode, increment and suppress flags |
| src_base | input | ADDR_W | Source start address |
| dst_base | input | ADDR_W | Destination start address |
| len_word | input | WORD_W | Linear byte count, or packed rows and row bytes |
| stride_word | input | WORD_W | Packed signed destination and source row strides |
| busy | output | 1 | A transfer is moving words |
| rd_req | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read address |
| rd_ready | input | 1 | Read accepted; rd_data valid in the same cycle |
| rd_data | input | WORD_W | Read word |
| wr_req | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | WORD_W | Write word |
| wr_ready | input | 1 | Write accepted |
| done | output | 1 | One-cycle completion pulse |
| remain_len | output | WORD_W | Live remaining length |

## Verification
On every cycle, the assertions check request exclusivity and that requests hold stable under back-pressure. They also check that suppressed reads and writes never appear, that zero data goes out when reads are suppressed, that a pointer never drifts when it neither steps nor wraps, that the byte count falls within a row, and that done is a single-cycle pulse. Only the bench scenarios can show the actual address sequences. These include the signed stride added between rows but not after the last row, ceil rounding of odd byte counts, and the remaining-length packing after each beat. They also cover the exact completion cycle, the immediate finish of empty descriptors, and the fact that a start during a run is ignored.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  // control-word flag positions (decoded by the descriptor fetch neighbour)
  localparam int CTL_2D   = 1;
  localparam int CTL_DINC = 4;
  localparam int CTL_DSKP = 7;
  localparam int CTL_SINC = 8;
  localparam int CTL_SSKP = 11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_FIN
  } xfer_st_e;

  typedef struct packed {
    logic mode2d;
    logic src_inc;
    logic dst_inc;
    logic src_skip;
    logic dst_skip;
  } xfer_flags_t;
endpackage

// File: rtl/dma2d_decode.sv
module dma2d_decode
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int ROW_W  = 14,
  parameter int XLEN_W = 16,
  parameter int STR_W  = 16
) (
  input  logic [31:0]       ctrl_word,
  input  logic [WORD_W-1:0] len_word,
  input  logic [WORD_W-1:0] stride_word,
  output xfer_flags_t       flags,
  output logic [ROW_W-1:0]  rows,
  output logic [WORD_W-1:0] row_bytes,
  output logic [ADDR_W-1:0] src_stride,
  output logic [ADDR_W-1:0] dst_stride,
  output logic              empty
);
  localparam int EXT_W = ADDR_W - STR_W;

  logic [STR_W-1:0] s_lo, s_hi;

  always_comb begin
    flags.mode2d   = ctrl_word[CTL_2D];
    flags.src_inc  = ctrl_word[CTL_SINC];
    flags.dst_inc  = ctrl_word[CTL_DINC];
    flags.src_skip = ctrl_word[CTL_SSKP];
    flags.dst_skip = ctrl_word[CTL_DSKP];

    s_lo = stride_word[STR_W-1:0];
    s_hi = stride_word[2*STR_W-1:STR_W];

    if (flags.mode2d) begin
      rows       = len_word[XLEN_W +: ROW_W];
      row_bytes  = {{(WORD_W-XLEN_W){1'b0}}, len_word[XLEN_W-1:0]};
      src_stride = {{EXT_W{s_lo[STR_W-1]}}, s_lo};
      dst_stride = {{EXT_W{s_hi[STR_W-1]}}, s_hi};
    end else begin
      rows       = ROW_W'(1);
      row_bytes  = len_word;
      src_stride = '0;
      dst_stride = '0;
    end
    empty = (rows == '0) || (row_bytes == '0);
  end
endmodule

// File: rtl/dma2d_count.sv
module dma2d_count #(
  parameter int WORD_W = 32,
  parameter int ROW_W  = 14,
  parameter int XLEN_W = 16,
  parameter int BEAT_B = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              mode2d_in,
  input  logic [ROW_W-1:0]  rows_in,
  input  logic [WORD_W-1:0] bytes_in,
  input  logic              beat,
  output logic              row_wrap,
  output logic              job_last,
  output logic [WORD_W-1:0] remain
);
  logic [ROW_W-1:0]  rows_left;
  logic [WORD_W-1:0] bytes_left, row_bytes_q, next_bytes;
  logic              mode_q, tail;

  function automatic logic [WORD_W-1:0] pack(input logic [ROW_W-1:0] r,
                                             input logic [WORD_W-1:0] b);
    logic [WORD_W-1:0] p;
    p = '0;
    p[XLEN_W +: ROW_W] = r;
    p[XLEN_W-1:0]      = b[XLEN_W-1:0];
    return p;
  endfunction

  always_comb begin
    tail       = bytes_left <= WORD_W'(BEAT_B);
    next_bytes = tail ? '0 : bytes_left - WORD_W'(BEAT_B);
    row_wrap   = tail && (rows_left != ROW_W'(1));
    job_last   = tail && (rows_left == ROW_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rows_left   <= '0;
      bytes_left  <= '0;
      row_bytes_q <= '0;
      mode_q      <= 1'b0;
      remain      <= '0;
    end else if (load) begin
      rows_left   <= rows_in;
      bytes_left  <= bytes_in;
      row_bytes_q <= bytes_in;
      mode_q      <= mode2d_in;
      remain      <= mode2d_in ? pack(rows_in, bytes_in) : bytes_in;
    end else if (beat) begin
      remain <= mode_q ? pack(rows_left, next_bytes) : next_bytes;
      if (row_wrap) begin
        rows_left  <= rows_left - ROW_W'(1);
        bytes_left <= row_bytes_q;
      end else begin
        bytes_left <= next_bytes;
      end
    end
  end

  assert_bytes_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (beat && !load && !tail) |=> (bytes_left < $past(bytes_left)));

  assert_row_reload_R3: assert property (@(posedge clk) disable iff (rst)
    (beat && !load && row_wrap) |=> (bytes_left == row_bytes_q));
endmodule

// File: rtl/dma2d_ptr.sv
module dma2d_ptr #(
  parameter int ADDR_W = 32,
  parameter int BEAT_B = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              beat,
  input  logic              inc_en,
  input  logic              wrap,
  input  logic [ADDR_W-1:0] stride,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] step;

  always_comb begin
    step = inc_en ? ADDR_W'(BEAT_B) : '0;
    if (wrap) step = step + stride;
  end

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= base;
    else if (beat) addr <= addr + step;
  end

  assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && !(beat && (inc_en || wrap))) |=> $stable(addr));
endmodule

// File: rtl/dma2d_agen.sv
module dma2d_agen
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int ROW_W  = 14,
  parameter int XLEN_W = 16,
  parameter int STR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       ctrl_word,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [WORD_W-1:0] len_word,
  input  logic [WORD_W-1:0] stride_word,
  output logic              busy,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic [WORD_W-1:0] rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  input  logic              wr_ready,
  output logic              done,
  output logic [WORD_W-1:0] remain_len
);
  localparam int BEAT_B = WORD_W / 8;

  xfer_st_e          st, st_nx;
  xfer_flags_t       dec_fl, fl_q;
  logic [ROW_W-1:0]  dec_rows;
  logic [WORD_W-1:0] dec_bytes, data_q;
  logic [ADDR_W-1:0] dec_sstr, dec_dstr, sstr_q, dstr_q;
  logic              dec_empty, launch, beat, row_wrap, job_last;

  dma2d_decode #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .ROW_W(ROW_W),
    .XLEN_W(XLEN_W), .STR_W(STR_W)
  ) u_dec (
    .ctrl_word(ctrl_word), .len_word(len_word), .stride_word(stride_word),
    .flags(dec_fl), .rows(dec_rows), .row_bytes(dec_bytes),
    .src_stride(dec_sstr), .dst_stride(dec_dstr), .empty(dec_empty)
  );

  dma2d_count #(
    .WORD_W(WORD_W), .ROW_W(ROW_W), .XLEN_W(XLEN_W), .BEAT_B(BEAT_B)
  ) u_cnt (
    .clk(clk), .rst(rst), .load(launch), .mode2d_in(dec_fl.mode2d),
    .rows_in(dec_rows), .bytes_in(dec_bytes), .beat(beat),
    .row_wrap(row_wrap), .job_last(job_last), .remain(remain_len)
  );

  dma2d_ptr #(.ADDR_W(ADDR_W), .BEAT_B(BEAT_B)) u_src (
    .clk(clk), .rst(rst), .load(launch), .base(src_base), .beat(beat),
    .inc_en(fl_q.src_inc), .wrap(row_wrap), .stride(sstr_q), .addr(rd_addr)
  );

  dma2d_ptr #(.ADDR_W(ADDR_W), .BEAT_B(BEAT_B)) u_dst (
    .clk(clk), .rst(rst), .load(launch), .base(dst_base), .beat(beat),
    .inc_en(fl_q.dst_inc), .wrap(row_wrap), .stride(dstr_q), .addr(wr_addr)
  );

  always_comb begin
    launch = start && ((st == ST_IDLE) || (st == ST_FIN));
    beat   = ((st == ST_RD) && rd_ready && fl_q.dst_skip) ||
             ((st == ST_WR) && (wr_ready || fl_q.dst_skip));
    st_nx  = st;
    unique case (st)
      ST_IDLE, ST_FIN: begin
        st_nx = ST_IDLE;
        if (launch) begin
          if (dec_empty)            st_nx = ST_FIN;
          else if (dec_fl.src_skip) st_nx = ST_WR;
          else                      st_nx = ST_RD;
        end
      end
      ST_RD: if (rd_ready) st_nx = fl_q.dst_skip ? (job_last ? ST_FIN : ST_RD) : ST_WR;
      ST_WR: if (beat) st_nx = job_last ? ST_FIN : (fl_q.src_skip ? ST_WR : ST_RD);
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      fl_q   <= '0;
      sstr_q <= '0;
      dstr_q <= '0;
      data_q <= '0;
    end else begin
      st <= st_nx;
      if (launch) begin
        fl_q   <= dec_fl;
        sstr_q <= dec_sstr;
        dstr_q <= dec_dstr;
        data_q <= '0;
      end else if ((st == ST_RD) && rd_ready) begin
        data_q <= rd_data;
      end
    end
  end

  assign busy    = (st == ST_RD) || (st == ST_WR);
  assign rd_req  = (st == ST_RD);
  assign wr_req  = (st == ST_WR) && !fl_q.dst_skip;
  assign wr_data = data_q;
  assign done    = (st == ST_FIN);

  assert_one_port_R7: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && wr_req));

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));

  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ready) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  assert_no_read_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && fl_q.src_skip) |-> !rd_req);

  assert_zero_data_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_req && fl_q.src_skip) |-> (wr_data == '0));

  assert_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && fl_q.dst_skip) |-> !wr_req);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/tb_dma2d_agen.sv
`timescale 1ns/1ps
module tb_dma2d_agen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] ctrl_word = '0, src_base = '0, dst_base = '0;
  logic [31:0] len_word = '0, stride_word = '0;
  logic        busy, rd_req, wr_req, done;
  logic [31:0] rd_addr, wr_addr, wr_data, remain_len;
  logic        rd_ready = 1'b0, wr_ready = 1'b0;
  logic [31:0] rd_data = '0;

  always #5 clk = ~clk;

  dma2d_agen dut (
    .clk(clk), .rst(rst), .start(start), .ctrl_word(ctrl_word),
    .src_base(src_base), .dst_base(dst_base), .len_word(len_word),
    .stride_word(stride_word), .busy(busy), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .done(done), .remain_len(remain_len)
  );

  typedef struct {
    bit          wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic [31:0] rem;
    bit          endb;
    string       tag;
  } item_t;

  item_t       exq[$];
  int          checks = 0, errors = 0;
  int          cyc = 0, last_acc = 0, stall = 0;
  bit          mon_on = 0, rem_pend = 0;
  logic [31:0] rem_exp;
  string       rem_tag;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: grants handshakes and compares against the scoreboard queue
  always @(negedge clk) begin
    if (mon_on) begin
      bit go;
      item_t it;
      if (rem_pend) begin
        chk(remain_len == rem_exp, {rem_tag, "/R8"}, "remain_len", remain_len, rem_exp);
        rem_pend = 0;
      end
      go = (stall == 0) || ((cyc % 3) != 0);
      rd_ready = 1'b0;
      wr_ready = 1'b0;
      if (rd_req && wr_req) chk(1'b0, "R7", "both requests", 32'd1, 32'd0);
      if (rd_req && go) begin
        rd_ready = 1'b1;
        rd_data  = memf(rd_addr);
        if (exq.size() == 0) chk(1'b0, "R7", "unexpected read", rd_addr, 32'hx);
        else begin
          it = exq.pop_front();
          chk(!it.wr && rd_addr == it.addr, it.tag, "read addr", rd_addr, it.addr);
          if (it.endb) begin rem_pend = 1; rem_exp = it.rem; rem_tag = it.tag; end
          last_acc = cyc;
        end
      end else if (wr_req && go) begin
        wr_ready = 1'b1;
        if (exq.size() == 0) chk(1'b0, "R7", "unexpected write", wr_addr, 32'hx);
        else begin
          it = exq.pop_front();
          chk(it.wr && wr_addr == it.addr, it.tag, "write addr", wr_addr, it.addr);
          chk(wr_data == it.data, it.tag, "write data", wr_data, it.data);
          if (it.endb) begin rem_pend = 1; rem_exp = it.rem; rem_tag = it.tag; end
          last_acc = cyc;
        end
      end
    end
  end

  // driver: builds the expected sequence, launches, checks completion
  task automatic run(input logic [31:0] ctl, input logic [31:0] s0,
                     input logic [31:0] d0, input logic [31:0] len,
                     input logic [31:0] str, input string tag, input bit poke);
    bit          m2d, sinc, dinc, sskp, dskp, zero;
    int          rows, st_cyc, n;
    logic [31:0] rb, b, nb, s, d, ss, ds, dat, rem, fin;
    item_t       it;
    m2d  = ctl[1];  dinc = ctl[4]; dskp = ctl[7];
    sinc = ctl[8];  sskp = ctl[11];
    rows = m2d ? int'(len[29:16]) : 1;
    rb   = m2d ? {16'd0, len[15:0]} : len;
    ss   = m2d ? {{16{str[15]}}, str[15:0]} : 32'd0;
    ds   = m2d ? {{16{str[31]}}, str[31:16]} : 32'd0;
    zero = (rows == 0) || (rb == 0);
    fin  = m2d ? {2'b00, len[29:0]} : len;
    s = s0; d = d0;
    if (!zero) begin
      for (int r = 0; r < rows; r++) begin
        b = rb;
        while (b != 0) begin
          nb  = (b <= 4) ? 32'd0 : b - 4;
          rem = m2d ? {2'b00, 14'(rows - r), nb[15:0]} : nb;
          dat = sskp ? 32'd0 : memf(s);
          if (!sskp) begin
            it = '{wr: 0, addr: s, data: 0, rem: rem, endb: dskp, tag: tag};
            exq.push_back(it);
          end
          if (!dskp) begin
            it = '{wr: 1, addr: d, data: dat, rem: rem, endb: 1, tag: tag};
            exq.push_back(it);
          end
          fin = rem;
          if (sinc) s = s + 4;
          if (dinc) d = d + 4;
          b = nb;
        end
        if (r < rows - 1) begin s = s + ss; d = d + ds; end
      end
    end
    @(negedge clk);
    ctrl_word = ctl; src_base = s0; dst_base = d0;
    len_word = len; stride_word = str; start = 1'b1;
    st_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R11", "busy mid-run", {31'd0, busy}, 32'd1);
      ctrl_word = 32'h0000_0002; len_word = 32'd0;
      src_base = 32'hDEAD_0000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done == 1'b1, {tag, "/R9"}, "done seen", {31'd0, done}, 32'd1);
    chk(cyc == (zero ? st_cyc + 1 : last_acc + 1), zero ? {tag, "/R10"} : {tag, "/R9"},
        "done cycle", cyc, zero ? st_cyc + 1 : last_acc + 1);
    chk(busy == 1'b0, {tag, "/R9"}, "busy at done", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk(done == 1'b0, {tag, "/R9"}, "done width", {31'd0, done}, 32'd0);
    chk(exq.size() == 0, tag, "items left", exq.size(), 32'd0);
    chk(remain_len == fin, {tag, "/R8"}, "final remain", remain_len, fin);
    exq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", cyc, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !rd_req && !wr_req && !done, "R1", "idle outputs",
        {28'd0, busy, rd_req, wr_req, done}, 32'd0);
    chk(remain_len == 0, "R1", "remain after reset", remain_len, 32'd0);
    mon_on = 1;
    // R2/R4 linear, both pointers stepping, 4 beats
    run(32'h0000_0110, 32'h0000_1000, 32'h0000_2000, 32'd16, 32'h0, "R2", 0);
    // R2 odd count rounds up; R4 fixed source
    stall = 1;
    run(32'h0000_0010, 32'h0000_1100, 32'h0000_3000, 32'd10, 32'h0, "R2", 0);
    // R3 2D with negative source stride, positive destination stride
    run(32'h0000_0112, 32'h0000_4000, 32'h0000_5000, 32'h0003_0008,
        32'h0020_FFFC, "R3", 0);
    // R3 top bits of length ignored, fixed pointers use stride only
    stall = 0;
    run(32'h0000_0002, 32'h0000_6000, 32'h0000_7000, 32'hC002_0004,
        32'hFF00_0100, "R3", 0);
    // R5 source suppressed, zero written
    run(32'h0000_0810, 32'h0000_8000, 32'h0000_9000, 32'd12, 32'h0, "R5", 0);
    // R6 destination suppressed, 2D reads only
    stall = 1;
    run(32'h0000_0182, 32'h0000_A000, 32'h0000_B000, 32'h0002_0008,
        32'h0000_0010, "R6", 0);
    // R10 zero bytes, zero rows
    stall = 0;
    run(32'h0000_0110, 32'h0000_1000, 32'h0000_2000, 32'd0, 32'h0, "R10", 0);
    run(32'h0000_0112, 32'h0000_1000, 32'h0000_2000, 32'h0000_0008, 32'h4, "R10", 0);
    // R11 start while busy is ignored
    stall = 1;
    run(32'h0000_0110, 32'h0000_C000, 32'h0000_D000, 32'd24, 32'h0, "R11", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule